// File: doc/BRIEF.md
# Tagged Floating-Point Register Stack

This block holds eight 80-bit registers in double-extended floating-point layout (sign in bit 79, a 15-bit exponent in bits 78:64, a 64-bit significand in bits 63:0). Normal accesses treat the registers as a circular stack. A 3-bit top pointer selects the current top entry, and stack offset i names physical register (top + i) mod 8. Every register carries a 2-bit class tag, and the block computes that tag from each value it writes.

A second, flat mode serves packed-integer SIMD code. It reaches the same physical registers by absolute index and uses only the low 64 bits. A SIMD write resets the stack view. A separate clear command gives the registers back to stack use by marking every entry empty.

A push onto an occupied slot raises a one-cycle overflow flag. Popping, reading or exchanging an empty entry raises a one-cycle underflow flag. A faulting command changes no register, tag or pointer.

Top module: `fp_stack_rf`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) sets top to 0, every tag to 11 (empty) and both fault flags to 0.
- R2: The tag of a written value is 01 (zero) when the exponent and significand are both 0. It is 10 (special) when the exponent is all ones, or when the exponent is 0 and the significand is nonzero. Otherwise it is 00 (valid). The tag of physical register k is tags[2k+1:2k].
- R3: PUSH (op 1) decrements top modulo 8 and writes wdata, with its computed tag, into the new top register. If that register is not empty, overflow is raised and nothing changes.
- R4: POP (op 2) presents ST(idx) on rdata, marks the old top empty and increments top modulo 8. If ST(0) is empty, underflow is raised and nothing changes.
- R5: Outside SIMD reads, rdata combinationally shows physical register (top + idx) mod 8. READ (op 4) raises underflow when that entry is empty.
- R6: XCH (op 3) swaps the data and tags of ST(0) and ST(idx). If either entry is empty, underflow is raised and nothing changes.
- R7: SIMD write (op 5) stores wdata[63:0] into physical register idx with bits 79:64 set to all ones. It sets top to 0 and every tag to 00. It never faults.
- R8: During SIMD read (op 6), rdata shows physical register idx with bits 79:64 forced to 0. It never faults.
- R9: CLEAR (op 7) sets every tag to 11 and leaves top and the register data unchanged.
- R10: The overflow and underflow flags are registered. Each is high for exactly the one cycle after the faulting command, and 0 after op 0 (no operation).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op | input | 3 | Command: 0 nop, 1 push, 2 pop, 3 exchange, 4 read, 5 SIMD write, 6 SIMD read, 7 clear |
| idx | input | 3 | Stack offset, or absolute index in SIMD commands |
| wdata | input | 80 | Write data |
| rdata | output | 80 | Read data (combinational) |
| top | output | 3 | Top-of-stack pointer |
| tags | output | 16 | Tag word, two bits per physical register |
| ovf | output | 1 | Stack overflow pulse |
| unf | output | 1 | Stack underflow pulse |

## Verification
The assertions assume that op and idx are stable around the rising edge and that rst is high at the first edge. The step that follows a fault is assumed to leave the pointer and tags unchanged, which holds only if no other command is folded into a faulting cycle. The driver changes inputs only at falling edges and issues exactly one command per cycle. It opens with a reset long enough to clear the pointer and the tags.

// File: rtl/fp_stack_rf.sv
module fp_stack_rf #(
  parameter int DW   = 80,
  parameter int SW   = 64,
  parameter int NREG = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [2:0]           op,
  input  logic [$clog2(NREG)-1:0] idx,
  input  logic [DW-1:0]        wdata,
  output logic [DW-1:0]        rdata,
  output logic [$clog2(NREG)-1:0] top,
  output logic [2*NREG-1:0]    tags,
  output logic                 ovf,
  output logic                 unf
);
  localparam int AW = $clog2(NREG);
  localparam int EW = DW - SW - 1;
  localparam logic [2:0] OP_PUSH = 3'd1, OP_POP = 3'd2, OP_XCH = 3'd3,
                         OP_READ = 3'd4, OP_SWR = 3'd5, OP_SRD = 3'd6, OP_CLR = 3'd7;
  localparam logic [1:0] T_VAL = 2'b00, T_ZERO = 2'b01, T_SPEC = 2'b10, T_EMPTY = 2'b11;

  logic [DW-1:0] regs [NREG];
  logic [1:0]    tg   [NREG];
  logic [AW-1:0] tp;

  function automatic logic [1:0] class_of(input logic [DW-1:0] v);
    logic [EW-1:0] e;
    logic [SW-1:0] m;
    e = v[DW-2:SW];
    m = v[SW-1:0];
    if (e == '0 && m == '0)        class_of = T_ZERO;
    else if (&e || e == '0)        class_of = T_SPEC;
    else                           class_of = T_VAL;
  endfunction

  wire [AW-1:0] dn  = tp - 1'b1;
  wire [AW-1:0] rel = tp + idx;

  wire push_f = (op == OP_PUSH) && (tg[dn] != T_EMPTY);
  wire pop_f  = (op == OP_POP)  && (tg[tp] == T_EMPTY);
  wire rd_f   = (op == OP_READ) && (tg[rel] == T_EMPTY);
  wire xch_f  = (op == OP_XCH)  && ((tg[tp] == T_EMPTY) || (tg[rel] == T_EMPTY));

  assign rdata = (op == OP_SRD) ? {{(DW-SW){1'b0}}, regs[idx][SW-1:0]} : regs[rel];
  assign top   = tp;

  for (genvar k = 0; k < NREG; k++) begin : g_tags
    assign tags[2*k+1:2*k] = tg[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tp  <= '0;
      ovf <= 1'b0;
      unf <= 1'b0;
      for (int k = 0; k < NREG; k++) tg[k] <= T_EMPTY;
    end else begin
      ovf <= push_f;
      unf <= pop_f | rd_f | xch_f;
      case (op)
        OP_PUSH: if (!push_f) begin
          tp       <= dn;
          regs[dn] <= wdata;
          tg[dn]   <= class_of(wdata);
        end
        OP_POP: if (!pop_f) begin
          tg[tp] <= T_EMPTY;
          tp     <= tp + 1'b1;
        end
        OP_XCH: if (!xch_f) begin
          regs[tp]  <= regs[rel];
          regs[rel] <= regs[tp];
          tg[tp]    <= tg[rel];
          tg[rel]   <= tg[tp];
        end
        OP_SWR: begin
          regs[idx] <= {{(DW-SW){1'b1}}, wdata[SW-1:0]};
          tp        <= '0;
          for (int k = 0; k < NREG; k++) tg[k] <= T_VAL;
        end
        OP_CLR: for (int k = 0; k < NREG; k++) tg[k] <= T_EMPTY;
        default: ;
      endcase
    end
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (tp == '0 && (&tags) && !ovf && !unf));
  assert_push_moves_top_R3: assert property (@(posedge clk) disable iff (rst)
    (op == OP_PUSH && !push_f) |=> tp == AW'($past(tp) - 1'b1));
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    ovf |-> ($stable(tp) && $stable(tags)));
  assert_pop_moves_top_R4: assert property (@(posedge clk) disable iff (rst)
    (op == OP_POP && !pop_f) |=> tp == AW'($past(tp) + 1'b1));
  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (rst)
    unf |-> ($stable(tp) && $stable(tags)));
  assert_simd_write_R7: assert property (@(posedge clk) disable iff (rst)
    (op == OP_SWR) |=> (tp == '0 && tags == '0 && !ovf && !unf));
  assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (op == OP_CLR) |=> ((&tags) && $stable(tp)));
  assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    !(ovf && unf));
endmodule

// File: tb/fp_stack_rf_tb.sv
module fp_stack_rf_tb;
  logic clk = 1'b0, rst = 1'b1;
  logic [2:0] op = 3'd0, idx = 3'd0;
  logic [79:0] wdata = '0, rdata;
  logic [2:0] top;
  logic [15:0] tags;
  logic ovf, unf;

  always #2.5 clk = ~clk;

  fp_stack_rf u_dut (.clk(clk), .rst(rst), .op(op), .idx(idx), .wdata(wdata),
                     .rdata(rdata), .top(top), .tags(tags), .ovf(ovf), .unf(unf));

  int checks = 0, errors = 0;
  logic [79:0] md [8];
  logic [1:0]  mt [8];
  logic [2:0]  mtop;
  logic [20:0] expq [$];
  string       reqq [$];

  function automatic logic [1:0] cls(input logic [79:0] v);
    if (v[78:64] == 0 && v[63:0] == 0) return 2'b01;
    if (v[78:64] == 15'h7fff || v[78:64] == 0) return 2'b10;
    return 2'b00;
  endfunction

  function automatic logic [15:0] mtags();
    logic [15:0] t;
    for (int k = 0; k < 8; k++) t[2*k+:2] = mt[k];
    return t;
  endfunction

  task automatic check(input string req, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] o, input logic [2:0] i, input logic [79:0] w,
                      input string req, input bit chk_rd);
    logic [79:0] er;
    logic [2:0] r, d;
    logic eo, eu;
    @(negedge clk);
    op = o; idx = i; wdata = w;
    #1;
    r = mtop + i; d = mtop - 3'd1;
    er = (o == 3'd6) ? {16'h0, md[i][63:0]} : md[r];
    if (chk_rd) check({req, " rdata"}, rdata, er);
    eo = 0; eu = 0;
    case (o)
      3'd1: if (mt[d] != 2'b11) eo = 1; else begin mtop = d; md[d] = w; mt[d] = cls(w); end
      3'd2: if (mt[mtop] == 2'b11) eu = 1; else begin mt[mtop] = 2'b11; mtop = mtop + 3'd1; end
      3'd3: if (mt[mtop] == 2'b11 || mt[r] == 2'b11) eu = 1;
            else begin
              logic [79:0] tv; logic [1:0] tt;
              tv = md[mtop]; md[mtop] = md[r]; md[r] = tv;
              tt = mt[mtop]; mt[mtop] = mt[r]; mt[r] = tt;
            end
      3'd4: if (mt[r] == 2'b11) eu = 1;
      3'd5: begin md[i] = {16'hffff, w[63:0]}; mtop = 0; for (int k = 0; k < 8; k++) mt[k] = 2'b00; end
      3'd7: for (int k = 0; k < 8; k++) mt[k] = 2'b11;
      default: ;
    endcase
    expq.push_back({mtop, mtags(), eo, eu});
    reqq.push_back(req);
  endtask

  always @(negedge clk) begin
    if (expq.size() > 0) begin
      logic [20:0] e;
      string q;
      e = expq.pop_front();
      q = reqq.pop_front();
      check({q, " state"}, {59'h0, top, tags, ovf, unf}, {59'h0, e});
    end
  end

  localparam logic [79:0] V1 = {1'b0, 15'h3fff, 64'h8000_0000_0000_0000};
  localparam logic [79:0] V2 = {1'b1, 15'h4001, 64'hc000_0000_0000_0001};
  localparam logic [79:0] ZR = 80'h0;
  localparam logic [79:0] IN = {1'b0, 15'h7fff, 64'h8000_0000_0000_0000};
  localparam logic [79:0] DN = {1'b0, 15'h0000, 64'h0000_0000_0000_0001};

  initial begin
    for (int k = 0; k < 8; k++) begin md[k] = '0; mt[k] = 2'b11; end
    mtop = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    check("R1 reset", {59'h0, top, tags, ovf, unf}, {59'h0, 3'd0, 16'hffff, 2'b00});
    for (int k = 0; k < 8; k++) u_dut.regs[k] = '0;
    step(3'd1, 0, V1, "R3 push valid", 0);
    step(3'd1, 0, ZR, "R2 push zero", 0);
    step(3'd1, 0, IN, "R2 push infinity", 0);
    step(3'd1, 0, DN, "R2 push denormal", 0);
    step(3'd4, 3, 0, "R5 read ST3", 1);
    step(3'd4, 1, 0, "R5 read ST1", 1);
    step(3'd4, 5, 0, "R5 read empty", 1);
    step(3'd0, 0, 0, "R10 flag clears", 0);
    step(3'd3, 2, 0, "R6 exchange", 0);
    step(3'd4, 0, 0, "R6 new ST0", 1);
    step(3'd4, 2, 0, "R6 new ST2", 1);
    step(3'd3, 6, 0, "R6 exchange empty", 0);
    step(3'd2, 0, 0, "R4 pop", 1);
    for (int k = 0; k < 5; k++) step(3'd1, 0, V2, "R3 fill", 0);
    step(3'd1, 0, V1, "R3 overflow", 0);
    step(3'd0, 0, 0, "R10 ovf clears", 0);
    for (int k = 0; k < 8; k++) step(3'd2, 0, 0, "R4 drain", 1);
    step(3'd2, 0, 0, "R4 pop empty", 0);
    step(3'd5, 3, 80'h1234_0123_4567_89ab_cdef, "R7 simd write", 0);
    step(3'd6, 3, 0, "R8 simd read", 1);
    step(3'd6, 5, 0, "R8 simd read other", 1);
    step(3'd4, 3, 0, "R7 upper ones", 1);
    step(3'd7, 0, 0, "R9 clear", 0);
    step(3'd4, 3, 0, "R9 data kept", 1);
    step(3'd1, 0, V2, "R3 push after clear", 0);
    step(3'd0, 0, 0, "R10 idle", 0);
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule